// File: doc/BRIEF.md
# Sticky Reset Cause Recorder

This block remembers why the chip was last reset. Each reset source sends a one-cycle pulse into the block, and the block sets a matching bit in a 32-bit cause word. The bit stays set until software clears it. Software reads the word directly and clears bits by writing ones to them, so firmware can find out after boot which reset source fired.

The sources fall into two groups. The low-voltage causes (bits 0 to 8) are erased whenever the low-voltage domain is re-initialised. The high-voltage causes (bits 16 to 30) follow a blocking rule: once one of them is recorded, or the watchdog bit is set, later high-voltage causes are not recorded. Power-on is the exception. It clears every other bit and never blocks anything. A configuration input selects the high-voltage product variant, and in that variant over-voltage, over-current and watchdog resets also erase the low-voltage bits. A parameter removes the power-management cause entirely.

Top module: `reset_cause_log`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cause_o` reads 0x40000000, with only bit 30 set.
- R2: Events set bits according to a fixed map:
  - Low-voltage bits, from `lv_evt_i`: index 0 is watchdog (bit 0), 1 is active fault (bit 1), 2 is deep-sleep fault (bit 2), 3 is debugger (bit 3), 4 is software (bit 4), and 5..8 are multi-counter watchdogs 0..3 (bits 5..8).
  - High-voltage bits, from `hv_evt_i`: index 0 is the external pin (bit 16), 1..3 are brown-out on VDDD, VDDA and VCCD (bits 17..19), 4..6 are over-voltage on the same supplies (bits 20..22), 7..9 are over-current (bits 23..25), 10 is power management (bit 26), 11 is pin reset (bit 28) and 12 is structural reset (bit 29).
  - Power-on, from `por_evt_i`: bit 30.
  - A bit that is set appears on `cause_o` one cycle after its pulse.
- R3: A set bit stays set until software clears it. A write with `wr_en_i` high clears exactly those bits where `wr_data_i` is 1.
- R4: A power-on event leaves bit 30 set and clears every other bit, except events that arrive in the same cycle. Bit 30 never blocks the recording of high-voltage causes.
- R5: While any of bits 16..29 is set, a new high-voltage cause (bits 16..29) is not recorded, unless a power-on event arrives in the same cycle.
- R6: While bit 0 (watchdog) is set, new high-voltage causes (bits 16..29) are not recorded. The watchdog bit is never blocked by high-voltage bits.
- R7: Bits 0..8 are cleared on `lv_init_i`, on power-on, on an external-pin event and on any brown-out event.
- R8: With `hv_variant_i` high, over-voltage, over-current and watchdog events also clear bits 0..8. With `hv_variant_i` low, those events do not clear them.
- R9: With the parameter `PMIC_EN` set to 0, bit 26 never sets.
- R10: When a hardware clear and a new cause event land in the same cycle, the new event is recorded.
- R11: Bits 9..15, 27 and 31 always read 0, and writes to them have no effect.
- R12: When a software clear and a hardware set hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| lv_evt_i | input | 9 | Low-voltage cause pulses, one per source |
| hv_evt_i | input | 13 | High-voltage cause pulses, one per source |
| por_evt_i | input | 1 | Power-on event pulse |
| lv_init_i | input | 1 | Low-voltage domain initialisation (for example hibernate wakeup) |
| hv_variant_i | input | 1 | Selects the high-voltage product variant |
| wr_en_i | input | 1 | Write strobe for write-one-to-clear |
| wr_data_i | input | 32 | Write data; a 1 clears the matching bit |
| cause_o | output | 32 | Cause word as seen by software |

## Verification
The assertions assume that every input is a clean, known value sampled on the rising clock edge. They also assume that the event pulses, the initialisation strobe and the write strobe are each valid for a single cycle, with no meaning given to how long they are held. The stimulus keeps to this by changing inputs only on the falling edge and holding them low during reset. Random phases use sparse event pulses, so the blocking and clearing rules are reached both with and without other events in the same cycle. Directed steps build the exact collisions of power-on, domain initialisation, software clear and fresh events.

// File: rtl/reset_cause_log.sv
module reset_cause_log #(
  parameter bit PMIC_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [8:0]  lv_evt_i,
  input  logic [12:0] hv_evt_i,
  input  logic        por_evt_i,
  input  logic        lv_init_i,
  input  logic        hv_variant_i,
  input  logic        wr_en_i,
  input  logic [31:0] wr_data_i,
  output logic [31:0] cause_o
);

  localparam logic [31:0] LV_MASK   = 32'h0000_01FF;
  localparam logic [31:0] HV_MASK   = 32'h37FF_0000;
  localparam logic [31:0] POR_BIT   = 32'h4000_0000;
  localparam logic [31:0] PMIC_BIT  = 32'h0400_0000;
  localparam logic [31:0] IMPL_MASK = LV_MASK | HV_MASK | POR_BIT;
  localparam logic [31:0] SET_MASK  = PMIC_EN ? IMPL_MASK : (IMPL_MASK & ~PMIC_BIT);

  logic [31:0] cause_q, cause_d;
  logic [31:0] hv_map, set_vec, hw_clr, sw_clr;
  logic        hv_block, lv_wipe;

  assign hv_map = {2'b00, hv_evt_i[12:11], 1'b0, hv_evt_i[10:0], 16'h0000};

  assign hv_block = !por_evt_i && (cause_q[0] || |(cause_q & HV_MASK));

  assign lv_wipe = lv_init_i || por_evt_i || |hv_evt_i[3:0] ||
                   (hv_variant_i && (|hv_evt_i[9:4] || lv_evt_i[0]));

  assign hw_clr = (por_evt_i ? ~POR_BIT : 32'h0) | (lv_wipe ? LV_MASK : 32'h0);
  assign sw_clr = wr_en_i ? wr_data_i : 32'h0;

  assign set_vec = {23'h0, lv_evt_i}
                 | (hv_block ? 32'h0 : hv_map)
                 | (por_evt_i ? POR_BIT : 32'h0);

  assign cause_d = (set_vec | (cause_q & ~hw_clr & ~sw_clr)) & SET_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= POR_BIT;
    else        cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  p_lv_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    |lv_evt_i |=> ((cause_q[8:0] & $past(lv_evt_i)) == $past(lv_evt_i)));

  p_hv_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_evt_i && !wr_en_i) |=> ((cause_q & $past(cause_q) & HV_MASK) == ($past(cause_q) & HV_MASK)));

  p_por_wipe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (por_evt_i && lv_evt_i == 9'd0 && hv_evt_i == 13'd0) |=> (cause_q == POR_BIT));

  p_hv_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_evt_i && (cause_q[0] || |(cause_q & HV_MASK))) |=> ((cause_q & ~$past(cause_q) & HV_MASK) == 32'h0));

  p_wdt_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lv_evt_i[0] |=> cause_q[0]);

  p_lv_init_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_init_i && lv_evt_i == 9'd0) |=> (cause_q[8:0] == 9'd0));

  p_variant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_variant_i && |hv_evt_i[9:4] && lv_evt_i == 9'd0) |=> (cause_q[8:0] == 9'd0));

  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_init_i && |lv_evt_i) |=> ((cause_q[8:0] & $past(lv_evt_i)) == $past(lv_evt_i)));

  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q & ~IMPL_MASK) == 32'h0);

  p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && |(wr_data_i[8:0] & lv_evt_i)) |=>
      ((cause_q[8:0] & $past(wr_data_i[8:0] & lv_evt_i)) == $past(wr_data_i[8:0] & lv_evt_i)));

  generate
    if (!PMIC_EN) begin : g_no_pmic
      p_pmic_off_r9: assert property (@(posedge clk) disable iff (!rst_n) !cause_q[26]);
    end
  endgenerate

endmodule

// File: tb/reset_cause_log_bench.sv
module reset_cause_log_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  lv = '0;
  logic [12:0] hv = '0;
  logic        por = 1'b0, init = 1'b0, vr = 1'b0, we = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] c_a, c_b;
  logic [31:0] m_a, m_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  reset_cause_log #(.PMIC_EN(1'b1)) u_reset_cause_log (
    .clk(clk), .rst_n(rst_n), .lv_evt_i(lv), .hv_evt_i(hv), .por_evt_i(por),
    .lv_init_i(init), .hv_variant_i(vr), .wr_en_i(we), .wr_data_i(wd), .cause_o(c_a));

  reset_cause_log #(.PMIC_EN(1'b0)) u_reset_cause_log_nopmic (
    .clk(clk), .rst_n(rst_n), .lv_evt_i(lv), .hv_evt_i(hv), .por_evt_i(por),
    .lv_init_i(init), .hv_variant_i(vr), .wr_en_i(we), .wr_data_i(wd), .cause_o(c_b));

  function automatic logic [31:0] ref_next(input logic [31:0] q, input bit pmic);
    logic [31:0] r, ev;
    bit blocked, wipe;
    blocked = 1'b0;
    if (!por) begin
      if (q[0]) blocked = 1'b1;
      for (int i = 16; i < 30; i++) if (q[i]) blocked = 1'b1;
    end
    wipe = init || por || (hv[3:0] != 4'd0) || (vr && ((hv[9:4] != 6'd0) || lv[0]));
    r = q;
    if (we) r = r & ~wd;
    if (por) r = r & 32'h4000_0000;
    if (wipe) r[8:0] = 9'd0;
    ev = '0;
    ev[8:0] = lv;
    if (!blocked) begin
      for (int i = 0; i < 11; i++) ev[16+i] = hv[i];
      ev[28] = hv[11];
      ev[29] = hv[12];
      if (!pmic) ev[26] = 1'b0;
    end
    if (por) ev[30] = 1'b1;
    return (r | ev) & 32'h77FF_01FF;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic [8:0] l, input logic [12:0] h, input logic p,
                      input logic it, input logic v, input logic w, input logic [31:0] d);
    @(negedge clk);
    lv = l; hv = h; por = p; init = it; vr = v; we = w; wd = d;
    @(posedge clk);
    #1;
    m_a = ref_next(m_a, 1'b1);
    m_b = ref_next(m_b, 1'b0);
  endtask

  task automatic clr_all();
    step('0, '0, 0, 0, 0, 1, 32'hFFFF_FFFF);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    m_a = 32'h4000_0000; m_b = 32'h4000_0000;
    repeat (3) @(posedge clk);
    #1 chk("R1 in reset", c_a, 32'h4000_0000);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", c_a, 32'h4000_0000);

    step('0, '0, 0, 0, 0, 1, 32'h4000_0000);
    chk("R3 clear por bit", c_a, 32'h0);
    step(9'h1FF, '0, 0, 0, 0, 0, 0);
    chk("R2 all lv bits", c_a, 32'h0000_01FF);
    step('0, '0, 0, 0, 0, 1, 32'h0000_00F0);
    chk("R3 partial w1c", c_a, 32'h0000_010F);
    step('0, '0, 0, 0, 0, 0, 0);
    chk("R3 hold", c_a, 32'h0000_010F);
    step('0, '0, 0, 1, 0, 0, 0);
    chk("R7 lv init wipe", c_a, 32'h0);
    step(9'h008, '0, 0, 1, 0, 0, 0);
    chk("R10 event beats init", c_a, 32'h0000_0008);
    step(9'h004, 13'h0001, 0, 0, 0, 0, 0);
    chk("R7 ext pin wipes lv, R2 bit16", c_a, 32'h0001_0004);
    step('0, 13'h0010, 0, 0, 0, 0, 0);
    chk("R5 ovd blocked by bit16", c_a, 32'h0001_0004);
    step('0, '0, 1, 0, 0, 0, 0);
    chk("R4 por wipes", c_a, 32'h4000_0000);
    step('0, 13'h0002, 0, 0, 0, 0, 0);
    chk("R4 por not blocker, R7 bod", c_a, 32'h4002_0000);
    step('0, 13'h0004, 0, 0, 0, 0, 0);
    chk("R5 bod vdda blocked", c_a, 32'h4002_0000);
    clr_all();
    chk("R3 clear all", c_a, 32'h0);
    step(9'h001, '0, 0, 0, 0, 0, 0);
    chk("R6 wdt sets", c_a, 32'h0000_0001);
    step('0, 13'h1000, 0, 0, 0, 0, 0);
    chk("R6 wdt blocks structural", c_a, 32'h0000_0001);
    clr_all();
    step('0, 13'h0800, 0, 0, 0, 0, 0);
    chk("R2 pin reset bit28", c_a, 32'h1000_0000);
    step(9'h001, '0, 0, 0, 0, 0, 0);
    chk("R6 wdt not blocked", c_a, 32'h1000_0001);
    clr_all();
    step(9'h1F0, '0, 0, 0, 0, 0, 0);
    step('0, 13'h0080, 0, 0, 1, 0, 0);
    chk("R8 variant ocd wipes lv", c_a, 32'h0080_0000);
    clr_all();
    step(9'h1F0, '0, 0, 0, 0, 0, 0);
    step('0, 13'h0080, 0, 0, 0, 0, 0);
    chk("R8 no variant keeps lv", c_a, 32'h0080_01F0);
    step(9'h010, '0, 0, 0, 0, 1, 32'h0000_0010);
    chk("R12 set beats w1c", c_a, 32'h0080_01F0);
    clr_all();
    step(9'h1F0, '0, 0, 0, 1, 0, 0);
    step(9'h001, '0, 0, 0, 1, 0, 0);
    chk("R8 variant wdt wipes others", c_a, 32'h0000_0001);
    clr_all();
    step(9'h1FF, 13'h1FFF, 0, 0, 0, 0, 0);
    chk("R2 R11 all sources", c_a, 32'h37FF_01FF);
    chk("R9 pmic disabled", c_b, 32'h33FF_01FF);
    step('0, '0, 0, 0, 0, 1, 32'h8800_FE00);
    chk("R11 reserved write no effect", c_a, 32'h37FF_01FF);
    m_a = c_a; m_b = c_b;

    for (int n = 0; n < 4000; n++) begin
      logic [8:0]  rl;
      logic [12:0] rh;
      rl = '0; rh = '0;
      for (int i = 0; i < 9; i++)  rl[i] = ($urandom_range(0, 39) == 0);
      for (int i = 0; i < 13; i++) rh[i] = ($urandom_range(0, 59) == 0);
      step(rl, rh, ($urandom_range(0, 199) == 0), ($urandom_range(0, 49) == 0),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) == 0), $urandom());
      chk("R5 random model", c_a, m_a);
      chk("R9 random model", c_b, m_b);
    end

    step('0, '0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule